// File: doc/BRIEF.md
# Serial I/Q Sample Framer

This block turns a stream of quantised baseband samples into a three-wire serial stream for a baseband processor. Each sample has an in-phase and a quadrature part, and each part has a sign bit and a magnitude bit. The block drives one data bit per cycle of its clock, a framing line, and a clock-enable for the output clock. A gate outside the block turns that clock-enable into the pad clock. The gate drives the pad clock in antiphase to the internal clock, so the receiver's rising edge falls in the middle of each data bit. While the receiver enable is high, the block runs in one of four fixed formats. The format is chosen by a 2-bit select.

Two formats stream continuously and mark every in-phase sign bit with a high framing pulse. One carries only sign bits. The other carries sign and magnitude for both parts. The other two formats send 8-bit groups. A low framing pulse marks the first bit of each group. After each group comes a run of idle cycles with the clock suppressed. The length of that run sets the effective sample rate. Samples arrive through a one-deep valid/ready buffer. If the buffer is empty when a new sample is due, the block flags an underrun and sends the previous sample again.

Top module: `iq_serial_framer`

## Requirements
- R1: While the receiver enable was low at the previous clock edge, and after reset, out_clk_en, out_data and out_sync are all 0 and no sample leaves the input buffer.
- R2: The format select is captured on the clock edge at which the receiver enable is first seen high. Changes to the select while the enable stays high have no effect on the output.
- R3: Format 2'b00: the period is 2 cycles, with bits I-sign then Q-sign. out_clk_en stays 1, and out_sync is 1 only on the I-sign bit.
- R4: Format 2'b11: the period is 4 cycles, with bits I-sign, I-mag, Q-sign, Q-mag. out_clk_en stays 1, and out_sync is 1 only on the I-sign bit.
- R5: Format 2'b01: each period is 12 cycles. It starts with 8 data bits, which are four samples each sent as I-sign then Q-sign. out_sync is 0 only on the first of these bits. Then come 4 idle cycles with out_clk_en=0, out_data=0 and out_sync=1.
- R6: Format 2'b10: the same group of 8 data bits as R5, followed by 8 idle cycles at the same idle levels.
- R7: smp_ready is 1 exactly when the one-deep buffer is empty. A sample is accepted when smp_valid and smp_ready are both high at a clock edge, and each sample is sent in exactly one slot, in the order accepted.
- R8: If the buffer is empty when a slot starts, underrun is 1 for the first cycle of that slot only, and the slot repeats the previously sent sample.
- R9: The first bit of a frame appears in the cycle right after the edge that activates the block. Dropping the enable returns the outputs to their standby levels in the cycle after the edge that sees it low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock (sample-clock rate) |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_en | input | 1 | Receiver enable; low means standby |
| fmt_sel | input | 2 | Output format select |
| smp_valid | input | 1 | Input sample valid |
| smp_ready | output | 1 | Input buffer empty, ready to accept |
| smp_i_sign | input | 1 | In-phase sign bit |
| smp_i_mag | input | 1 | In-phase magnitude bit |
| smp_q_sign | input | 1 | Quadrature sign bit |
| smp_q_mag | input | 1 | Quadrature magnitude bit |
| out_clk_en | output | 1 | Output clock enable (0 during idle cycles and standby) |
| out_data | output | 1 | Serial data bit |
| out_sync | output | 1 | Framing line |
| underrun | output | 1 | Slot started with no buffered sample |

## Verification
The assertions assume that smp_valid stays low until the internal reset synchroniser has released. Otherwise a sample offered during that window would look like an accepted handshake while ready stays high. They also assume rx_en is driven to a known level from time zero, because the standby check looks at its previous value. The stimulus drives every input at a fixed offset after the falling edge. It holds rx_en low and the feeder off through reset, and it presents a new sample only when it has seen smp_ready high. This keeps the handshake one-deep and lets the expected bit sequence be predicted from the acceptance count alone.

// File: rtl/iq_fmt_pkg.sv
package iq_fmt_pkg;

  typedef enum logic [1:0] {
    FMT_PULSE2 = 2'b00,
    FMT_BYTE12 = 2'b01,
    FMT_BYTE16 = 2'b10,
    FMT_PULSE4 = 2'b11
  } fmt_e;

  typedef struct packed {
    logic i_sign;
    logic i_mag;
    logic q_sign;
    logic q_mag;
  } iq_smp_t;

endpackage

// File: rtl/iq_fmt_seq.sv
module iq_fmt_seq
  import iq_fmt_pkg::*;
#(
  parameter int BYTE_BITS  = 8,
  parameter int IDLE_SHORT = 4,
  parameter int IDLE_LONG  = 8,
  parameter int PH_W       = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            rx_en,
  input  logic [1:0]      fmt_sel,
  output logic            active,
  output fmt_e            mode,
  output logic [PH_W-1:0] phase,
  output logic            slot_load
);

  logic            act_q, act_n;
  fmt_e            mode_q, mode_n;
  logic [PH_W-1:0] ph_q, ph_n;

  function automatic logic [PH_W-1:0] last_ph(fmt_e m);
    case (m)
      FMT_PULSE2: return PH_W'(1);
      FMT_PULSE4: return PH_W'(3);
      FMT_BYTE12: return PH_W'(BYTE_BITS + IDLE_SHORT - 1);
      default:    return PH_W'(BYTE_BITS + IDLE_LONG - 1);
    endcase
  endfunction

  function automatic logic is_slot(fmt_e m, logic [PH_W-1:0] p);
    case (m)
      FMT_PULSE2: return !p[0];
      FMT_PULSE4: return (p == '0);
      default:    return !p[0] && (p < PH_W'(BYTE_BITS));
    endcase
  endfunction

  always_comb begin
    act_n     = act_q;
    mode_n    = mode_q;
    ph_n      = ph_q;
    slot_load = 1'b0;
    if (!rx_en) begin
      act_n = 1'b0;
      ph_n  = '0;
    end else if (!act_q) begin
      act_n     = 1'b1;
      mode_n    = fmt_e'(fmt_sel);
      ph_n      = '0;
      slot_load = 1'b1;
    end else begin
      ph_n      = (ph_q == last_ph(mode_q)) ? '0 : ph_q + PH_W'(1);
      slot_load = is_slot(mode_q, ph_n);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      mode_q <= FMT_PULSE2;
      ph_q   <= '0;
    end else begin
      act_q  <= act_n;
      mode_q <= mode_n;
      ph_q   <= ph_n;
    end
  end

  assign active = act_q;
  assign mode   = mode_q;
  assign phase  = ph_q;

endmodule

// File: rtl/iq_smp_buf.sv
module iq_smp_buf
  import iq_fmt_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    in_valid,
  output logic    in_ready,
  input  iq_smp_t in_smp,
  input  logic    load,
  output iq_smp_t cur,
  output logic    underrun
);

  iq_smp_t buf_q, buf_n, cur_q, cur_n;
  logic    full_q, full_n, unr_q, unr_n;
  logic    take, give;

  always_comb begin
    take   = in_valid && !full_q;
    give   = load && full_q;
    full_n = full_q;
    if (give)      full_n = 1'b0;
    else if (take) full_n = 1'b1;
    buf_n = take ? in_smp : buf_q;
    cur_n = give ? buf_q  : cur_q;
    unr_n = load && !full_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_q  <= '0;
      cur_q  <= '0;
      full_q <= 1'b0;
      unr_q  <= 1'b0;
    end else begin
      buf_q  <= buf_n;
      cur_q  <= cur_n;
      full_q <= full_n;
      unr_q  <= unr_n;
    end
  end

  assign in_ready = !full_q;
  assign cur      = cur_q;
  assign underrun = unr_q;

endmodule

// File: rtl/iq_bit_mux.sv
module iq_bit_mux
  import iq_fmt_pkg::*;
#(
  parameter int BYTE_BITS = 8,
  parameter int PH_W      = 4
) (
  input  logic            active,
  input  fmt_e            mode,
  input  logic [PH_W-1:0] phase,
  input  iq_smp_t         cur,
  output logic            clk_en,
  output logic            data,
  output logic            sync
);

  always_comb begin
    clk_en = 1'b0;
    data   = 1'b0;
    sync   = 1'b0;
    if (active) begin
      case (mode)
        FMT_PULSE2: begin
          clk_en = 1'b1;
          data   = phase[0] ? cur.q_sign : cur.i_sign;
          sync   = (phase == '0);
        end
        FMT_PULSE4: begin
          clk_en = 1'b1;
          case (phase[1:0])
            2'd0:    data = cur.i_sign;
            2'd1:    data = cur.i_mag;
            2'd2:    data = cur.q_sign;
            default: data = cur.q_mag;
          endcase
          sync = (phase == '0);
        end
        default: begin
          if (phase < PH_W'(BYTE_BITS)) begin
            clk_en = 1'b1;
            data   = phase[0] ? cur.q_sign : cur.i_sign;
            sync   = (phase != '0);
          end else begin
            clk_en = 1'b0;
            data   = 1'b0;
            sync   = 1'b1;
          end
        end
      endcase
    end
  end

endmodule

// File: rtl/iq_serial_framer.sv
module iq_serial_framer
  import iq_fmt_pkg::*;
#(
  parameter int BYTE_BITS  = 8,
  parameter int IDLE_SHORT = 4,
  parameter int IDLE_LONG  = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rx_en,
  input  logic [1:0] fmt_sel,
  input  logic       smp_valid,
  output logic       smp_ready,
  input  logic       smp_i_sign,
  input  logic       smp_i_mag,
  input  logic       smp_q_sign,
  input  logic       smp_q_mag,
  output logic       out_clk_en,
  output logic       out_data,
  output logic       out_sync,
  output logic       underrun
);

  localparam int PH_W = $clog2(BYTE_BITS + IDLE_LONG);

  logic [1:0]      rs_q;
  logic            rst_int_n;
  logic            active, slot_load;
  fmt_e            mode;
  logic [PH_W-1:0] phase;
  iq_smp_t         in_smp, cur;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_int_n = rs_q[1];

  assign in_smp = '{i_sign: smp_i_sign, i_mag: smp_i_mag,
                    q_sign: smp_q_sign, q_mag: smp_q_mag};

  iq_fmt_seq #(
    .BYTE_BITS(BYTE_BITS), .IDLE_SHORT(IDLE_SHORT),
    .IDLE_LONG(IDLE_LONG), .PH_W(PH_W)
  ) u_seq (
    .clk(clk), .rst_n(rst_int_n), .rx_en(rx_en), .fmt_sel(fmt_sel),
    .active(active), .mode(mode), .phase(phase), .slot_load(slot_load)
  );

  iq_smp_buf u_buf (
    .clk(clk), .rst_n(rst_int_n), .in_valid(smp_valid), .in_ready(smp_ready),
    .in_smp(in_smp), .load(slot_load), .cur(cur), .underrun(underrun)
  );

  iq_bit_mux #(.BYTE_BITS(BYTE_BITS), .PH_W(PH_W)) u_mux (
    .active(active), .mode(mode), .phase(phase), .cur(cur),
    .clk_en(out_clk_en), .data(out_data), .sync(out_sync)
  );

endmodule

// File: rtl/iq_framer_chk.sv
module iq_framer_chk (
  input logic clk,
  input logic rst_n,
  input logic rx_en,
  input logic smp_valid,
  input logic smp_ready,
  input logic out_clk_en,
  input logic out_data,
  input logic out_sync,
  input logic underrun
);

  assert_standby_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rx_en) |-> (!out_clk_en && !out_data && !out_sync));

  // R5 and R6: idle cycles hold the framing line high and data low
  assert_idle_levels_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rx_en) && !out_clk_en && rx_en) |-> (out_sync && !out_data));

  assert_one_deep_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && smp_ready) |=> !smp_ready);

  assert_underrun_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    underrun |=> !underrun);

  assert_drop_to_standby_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en |=> (!out_clk_en && !out_sync));

endmodule

bind iq_serial_framer iq_framer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .smp_valid(smp_valid),
  .smp_ready(smp_ready), .out_clk_en(out_clk_en), .out_data(out_data),
  .out_sync(out_sync), .underrun(underrun)
);

// File: tb/sim_iq_serial_framer.sv
`timescale 1ns/1ps
module sim_iq_serial_framer;

  logic clk = 1'b0;
  logic rst_n, rx_en, smp_valid, smp_ready;
  logic [1:0] fmt_sel;
  logic si, sm, sq, sqm;
  logic out_clk_en, out_data, out_sync, underrun;

  int n_tests = 0, n_fail = 0;
  int k = 0, base = 0;
  bit feed_on = 0, rdy_at_drive = 0, done = 0;

  always #10 clk = ~clk;

  iq_serial_framer u0 (
    .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .fmt_sel(fmt_sel),
    .smp_valid(smp_valid), .smp_ready(smp_ready),
    .smp_i_sign(si), .smp_i_mag(sm), .smp_q_sign(sq), .smp_q_mag(sqm),
    .out_clk_en(out_clk_en), .out_data(out_data), .out_sync(out_sync),
    .underrun(underrun)
  );

  function automatic logic [3:0] pat(int idx);
    return 4'((idx * 7 + 5) & 15);
  endfunction

  task automatic check(bit ok, string tag, int act, int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // sample feeder: drives just after the falling edge
  initial begin
    smp_valid = 0; {si, sm, sq, sqm} = 4'h0;
    forever begin
      @(negedge clk); #1;
      if (smp_valid && rdy_at_drive) k++;
      if (feed_on) begin
        smp_valid = 1; {si, sm, sq, sqm} = pat(k); rdy_at_drive = smp_ready;
      end else begin
        smp_valid = 0; rdy_at_drive = 0;
      end
    end
  end

  task automatic expect_bit(input logic [1:0] m, input int c, input int b,
                            output bit e_en, output bit e_d, output bit e_s);
    logic [3:0] s;
    int p, g, per;
    case (m)
      2'b00: begin s = pat(b + c/2); p = c % 2;
        e_en = 1; e_d = p ? s[1] : s[3]; e_s = (p == 0); end
      2'b11: begin s = pat(b + c/4); p = c % 4;
        e_en = 1; e_d = s[3 - p]; e_s = (p == 0); end
      default: begin
        per = (m == 2'b01) ? 12 : 16; g = c / per; p = c % per;
        if (p < 8) begin
          s = pat(b + g*4 + p/2);
          e_en = 1; e_d = (p % 2) ? s[1] : s[3]; e_s = (p != 0);
        end else begin
          e_en = 0; e_d = 0; e_s = 1;
        end
      end
    endcase
  endtask

  task automatic prefill_and_enable(input logic [1:0] m);
    fmt_sel = m; feed_on = 1;
    repeat (4) @(negedge clk);
    base = k - 1;
    rx_en = 1;
  endtask

  task automatic run_checks(input logic [1:0] m, input int n, input string tag);
    bit e_en, e_d, e_s;
    for (int c = 0; c < n; c++) begin
      @(negedge clk);
      expect_bit(m, c, base, e_en, e_d, e_s);
      check({out_clk_en, out_data, out_sync} == {e_en, e_d, e_s},
            $sformatf("%s cycle %0d {en,data,sync}", tag, c),
            {out_clk_en, out_data, out_sync}, {e_en, e_d, e_s});
      check(!underrun, $sformatf("%s cycle %0d underrun", tag, c), underrun, 0);
    end
  endtask

  task automatic stop_and_check_standby(input string tag);
    rx_en = 0; feed_on = 0;
    @(negedge clk);
    check({out_clk_en, out_data, out_sync} == 3'b000,
          {tag, " R9 drop to standby"}, {out_clk_en, out_data, out_sync}, 0);
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset;
    check({out_clk_en, out_data, out_sync, underrun} == 4'b0000,
          "R1 reset outputs quiet", {out_clk_en, out_data, out_sync, underrun}, 0);
    check(smp_ready == 1, "R7 ready after reset", smp_ready, 1);
  endtask

  task automatic t_standby_hold;
    feed_on = 1;
    repeat (3) @(negedge clk);
    check(smp_ready == 0, "R7 ready low when buffer full", smp_ready, 0);
    repeat (5) @(negedge clk);
    check(smp_ready == 0, "R1 buffer not drained in standby", smp_ready, 0);
    check({out_clk_en, out_data, out_sync} == 3'b000, "R1 standby quiet",
          {out_clk_en, out_data, out_sync}, 0);
    feed_on = 0;
    @(negedge clk);
  endtask

  task automatic t_mode(input logic [1:0] m, input string tag);
    prefill_and_enable(m);
    run_checks(m, 40, {tag, " R9 R7"});
    stop_and_check_standby(tag);
  endtask

  task automatic t_latch;
    prefill_and_enable(2'b11);
    run_checks(2'b11, 6, "R2 before change");
    fmt_sel = 2'b00;
    begin
      bit e_en, e_d, e_s;
      for (int c = 6; c < 26; c++) begin
        @(negedge clk);
        expect_bit(2'b11, c, base, e_en, e_d, e_s);
        check({out_clk_en, out_data, out_sync} == {e_en, e_d, e_s},
              $sformatf("R2 select ignored cycle %0d", c),
              {out_clk_en, out_data, out_sync}, {e_en, e_d, e_s});
      end
    end
    stop_and_check_standby("R2");
  endtask

  task automatic t_underrun;
    logic [3:0] s;
    fmt_sel = 2'b00; feed_on = 1;
    repeat (4) @(negedge clk);
    base = k - 1; s = pat(base);
    rx_en = 1; feed_on = 0;
    @(negedge clk);
    check(!underrun && out_data == s[3], "R8 first slot served", {underrun, out_data}, {1'b0, s[3]});
    @(negedge clk);
    check(!underrun && out_data == s[1], "R8 q bit", {underrun, out_data}, {1'b0, s[1]});
    @(negedge clk);
    check(underrun == 1, "R8 underrun flagged", underrun, 1);
    check(out_data == s[3] && out_sync == 1, "R8 previous sample repeated",
          {out_data, out_sync}, {s[3], 1'b1});
    @(negedge clk);
    check(underrun == 0, "R8 flag lasts one cycle", underrun, 0);
    check(out_data == s[1], "R8 repeated q bit", out_data, s[1]);
    @(negedge clk);
    check(underrun == 1, "R8 next slot flagged", underrun, 1);
    stop_and_check_standby("R8");
  endtask

  initial begin
    rst_n = 0; rx_en = 0; fmt_sel = 2'b00;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    t_reset();
    t_standby_hold();
    t_mode(2'b00, "R3");
    t_mode(2'b11, "R4");
    t_mode(2'b01, "R5");
    t_mode(2'b10, "R6");
    t_latch();
    t_underrun();
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule